// File: doc/BRIEF.md
# Half-Step Fractional Base-Rate Tick Generator

This block turns one fast parent clock into four independent base-rate tick streams. Each stream is a single-cycle clock-enable pulse. Its average rate is the parent rate divided by a divisor that moves in half steps, from 1 up to 128.5. Each channel takes its 8-bit divider code from its own byte of a packed 32-bit word. A channel runs a phase accumulator that gains 2 per parent cycle and gives up (2 + code) per tick. The stream therefore keeps an exact long-run rate and jitters by at most one cycle.

Software can load the packed word directly. It can also start the built-in calculator, which works from four target-rate inputs. The calculator scans candidate codes upward from zero, one candidate per cycle, and stops at the first code whose channel rate does not exceed the target. It resolves the channels one after another. It then writes the packed word itself and pulses a done flag. A channel adopts a new code only when its current tick interval ends, so no short period appears.

Top module: `baseTickGen`

## Requirements
- R1: During and after reset, before any write, divWordOut holds the word whose byte j is the calculator result for the default target of channel j at the default parent rate: 1, 4, 10 and 40 MHz at 100 MHz, giving 32'h031230C6. calcDone and ticks are low.
- R2: Bits [8j+7:8j] of the word set the code c of channel j, and the divisor is (2+c)/2. Once a code is in use, any 2+c consecutive cycles contain exactly two ticks on that channel.
- R3: Consecutive ticks of a channel are floor((2+c)/2) or ceil((2+c)/2) cycles apart, and both spacings occur when 2+c is odd.
- R4: With code 0, a channel ticks in every cycle.
- R5: A channel takes a new code only at its next tick. The interval in progress when the word changes completes with the old divisor.
- R6: When divWordWe is high at a clock edge, divWordIn appears on divWordOut in the next cycle. With no write and no commit, divWordOut holds its value.
- R7: A calcStart accepted while the calculator is idle sets byte j to the smallest c in 0..254 with PARENT_HZ*2 <= target_j*(2+c). If no such c exists, including a target of zero, byte j is set to 255. Target j sits at bits [32j+31:32j] of targetRates.
- R8: The calculator evaluates one candidate per cycle. Channel j uses c_j+1 cycles when c_j < 255, and 255 cycles otherwise. calcDone is high for exactly one cycle, N cycles after the edge that accepted calcStart, where N is the sum over the channels. The new word is visible on divWordOut in that same cycle.
- R9: If divWordWe is high at the edge where the calculator commits, the calculator result wins.
- R10: calcStart while a search is running is ignored. The search keeps its timing and produces exactly one done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rstN | input | 1 | Active-low synchronous reset |
| divWordIn | input | 32 | Packed divider codes to load |
| divWordWe | input | 1 | Load strobe for divWordIn |
| targetRates | input | 128 | Four 32-bit target rates in Hz, channel 0 lowest |
| calcStart | input | 1 | Start a code search |
| calcDone | output | 1 | One-cycle pulse when the searched word is committed |
| divWordOut | output | 32 | Packed divider codes in force |
| ticks | output | 4 | Per-channel tick pulses |

## Verification
Two pairs of functions can land on the same cycle.

The first pair is the calculator commit and a direct word write. The bench holds divWordWe high with a marker pattern through an entire search. It then judges that the marker is visible during the search and that the searched word replaces it on the done cycle.

The second pair is a channel tick and a word change. The bench writes a new code right at a tick of a channel running an even divisor. It then requires the next gap to match the old divisor exactly, and the gap after that to match the new one.

// File: rtl/fdivPkg.sv
package fdivPkg;
  localparam int NCH    = 4;
  localparam int CODE_W = 8;
  localparam int CH_W   = $clog2(NCH);

  typedef struct packed {
    logic            clearCand;
    logic            stepCand;
    logic            storeByte;
    logic            commitWord;
    logic [CH_W-1:0] chSel;
  } calcStrb_t;

  // smallest half-step code whose rate stays at or below the target
  function automatic logic [CODE_W-1:0] bestCode(longint unsigned parentHz,
                                                 longint unsigned targetHz);
    for (int c = 0; c < 255; c++) begin
      if (2 * parentHz <= targetHz * longint'(2 + c)) return CODE_W'(c);
    end
    return 8'hFF;
  endfunction
endpackage

// File: rtl/fdivChannel.sv
module fdivChannel #(
  parameter logic [7:0] RESET_CODE = 8'd0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] nextCode,
  output logic       tick,
  output logic [7:0] activeCode
);
  logic [8:0] accQ;
  logic [7:0] codeQ;
  logic       tickQ;
  logic [9:0] sum;
  logic [9:0] den;
  logic       fire;

  always_comb begin
    sum  = {1'b0, accQ} + 10'd2;
    den  = {2'b00, codeQ} + 10'd2;
    fire = (sum >= den);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ  <= '0;
      codeQ <= RESET_CODE;
      tickQ <= 1'b0;
    end else begin
      tickQ <= fire;
      if (fire) begin
        accQ  <= 9'(sum - den);
        codeQ <= nextCode;
      end else begin
        accQ  <= 9'(sum);
      end
    end
  end

  assign tick       = tickQ;
  assign activeCode = codeQ;
endmodule

// File: rtl/fdivCtrl.sv
module fdivCtrl
  import fdivPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      calcStart,
  input  logic      hit,
  output calcStrb_t strb,
  output logic      calcDone
);
  logic            busyQ;
  logic [CH_W-1:0] chQ;
  logic            doneQ;
  logic            lastCh;

  assign lastCh = (chQ == CH_W'(NCH - 1));

  always_comb begin
    strb       = '0;
    strb.chSel = chQ;
    if (!busyQ && calcStart) strb.clearCand = 1'b1;
    if (busyQ) begin
      if (hit) begin
        strb.storeByte  = 1'b1;
        strb.clearCand  = 1'b1;
        strb.commitWord = lastCh;
      end else begin
        strb.stepCand = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      chQ   <= '0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= busyQ && hit && lastCh;
      if (!busyQ) begin
        if (calcStart) begin
          busyQ <= 1'b1;
          chQ   <= '0;
        end
      end else if (hit) begin
        if (lastCh) busyQ <= 1'b0;
        else        chQ   <= chQ + 1'b1;
      end
    end
  end

  assign calcDone = doneQ;
endmodule

// File: rtl/fdivPath.sv
module fdivPath
  import fdivPkg::*;
#(
  parameter longint unsigned PARENT_HZ = 100_000_000,
  parameter int              RATE_W    = 32,
  parameter logic [31:0]     RESET_WORD = 32'h0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  calcStrb_t             strb,
  input  logic [NCH*RATE_W-1:0] targetRates,
  input  logic [31:0]           divWordIn,
  input  logic                  divWordWe,
  output logic                  hit,
  output logic [31:0]           divWordOut,
  output logic [31:0]           activeCodes,
  output logic [NCH-1:0]        ticks
);
  localparam int PROD_W = RATE_W + 10;
  localparam logic [PROD_W-1:0] NEED = PROD_W'(2 * PARENT_HZ);

  logic [CODE_W-1:0] candQ;
  logic [31:0]       stageQ;
  logic [31:0]       wordQ;
  logic [RATE_W-1:0] tgt;
  logic [PROD_W-1:0] reach;
  logic              met;
  logic [CODE_W-1:0] resolved;
  logic [31:0]       merged;

  always_comb begin
    tgt      = targetRates[strb.chSel*RATE_W +: RATE_W];
    reach    = PROD_W'(tgt) * PROD_W'({1'b0, candQ} + 9'd2);
    met      = (NEED <= reach);
    hit      = met || (candQ == 8'hFE);
    resolved = met ? candQ : 8'hFF;
    merged   = stageQ;
    merged[strb.chSel*CODE_W +: CODE_W] = resolved;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      candQ  <= '0;
      stageQ <= '0;
      wordQ  <= RESET_WORD;
    end else begin
      if (strb.clearCand)     candQ <= '0;
      else if (strb.stepCand) candQ <= candQ + 1'b1;
      if (strb.storeByte) stageQ <= merged;
      if (strb.commitWord) wordQ <= merged;
      else if (divWordWe)  wordQ <= divWordIn;
    end
  end

  for (genvar j = 0; j < NCH; j++) begin : g_ch
    fdivChannel #(.RESET_CODE(RESET_WORD[j*CODE_W +: CODE_W])) u_ch (
      .clk       (clk),
      .rstN      (rstN),
      .nextCode  (wordQ[j*CODE_W +: CODE_W]),
      .tick      (ticks[j]),
      .activeCode(activeCodes[j*CODE_W +: CODE_W])
    );
  end

  assign divWordOut = wordQ;
endmodule

// File: rtl/baseTickGen.sv
module baseTickGen
  import fdivPkg::*;
#(
  parameter longint unsigned PARENT_HZ = 100_000_000,
  parameter int              RATE_W    = 32,
  parameter longint unsigned DEF_RATE0 = 1_000_000,
  parameter longint unsigned DEF_RATE1 = 4_000_000,
  parameter longint unsigned DEF_RATE2 = 10_000_000,
  parameter longint unsigned DEF_RATE3 = 40_000_000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [31:0]           divWordIn,
  input  logic                  divWordWe,
  input  logic [NCH*RATE_W-1:0] targetRates,
  input  logic                  calcStart,
  output logic                  calcDone,
  output logic [31:0]           divWordOut,
  output logic [NCH-1:0]        ticks
);
  localparam logic [31:0] RESET_WORD = {bestCode(PARENT_HZ, DEF_RATE3),
                                        bestCode(PARENT_HZ, DEF_RATE2),
                                        bestCode(PARENT_HZ, DEF_RATE1),
                                        bestCode(PARENT_HZ, DEF_RATE0)};

  calcStrb_t   strb;
  logic        hit;
  logic [31:0] activeCodes;

  fdivCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .calcStart(calcStart),
    .hit      (hit),
    .strb     (strb),
    .calcDone (calcDone)
  );

  fdivPath #(
    .PARENT_HZ (PARENT_HZ),
    .RATE_W    (RATE_W),
    .RESET_WORD(RESET_WORD)
  ) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .targetRates(targetRates),
    .divWordIn  (divWordIn),
    .divWordWe  (divWordWe),
    .hit        (hit),
    .divWordOut (divWordOut),
    .activeCodes(activeCodes),
    .ticks      (ticks)
  );
endmodule

// File: rtl/baseTickGenChk.sv
module baseTickGenChk (
  input logic        clk,
  input logic        rstN,
  input logic [31:0] divWordIn,
  input logic        divWordWe,
  input logic        calcDone,
  input logic [31:0] divWordOut,
  input logic [3:0]  ticks,
  input logic [31:0] activeCodes
);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    calcDone |=> !calcDone);

  p_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(divWordWe) && !calcDone) |-> divWordOut == $past(divWordIn));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(divWordWe) && !calcDone) |-> $stable(divWordOut));

  for (genvar j = 0; j < 4; j++) begin : g_chk
    logic [8:0] gapQ;
    always_ff @(posedge clk) begin
      if (!rstN)         gapQ <= '0;
      else if (ticks[j]) gapQ <= 9'd1;
      else if (gapQ != 9'h1FF) gapQ <= gapQ + 9'd1;
    end

    p_code_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && activeCodes[8*j +: 8] != $past(activeCodes[8*j +: 8])) |-> ticks[j]);

    p_code0_r4: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && $past(activeCodes[8*j +: 8]) == 8'd0) |-> ticks[j]);

    p_spacing_r3: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && ticks[j]) |->
        (10'(gapQ) <= ((10'($past(activeCodes[8*j +: 8])) + 10'd3) >> 1)));
  end
endmodule

bind baseTickGen baseTickGenChk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .divWordIn  (divWordIn),
  .divWordWe  (divWordWe),
  .calcDone   (calcDone),
  .divWordOut (divWordOut),
  .ticks      (ticks),
  .activeCodes(activeCodes)
);

// File: tb/tb_baseTickGen.sv
module tb_baseTickGen;
  localparam longint unsigned P = 100_000_000;

  logic         clk = 1'b0;
  logic         rstN;
  logic [31:0]  divWordIn;
  logic         divWordWe;
  logic [127:0] targetRates;
  logic         calcStart;
  logic         calcDone;
  logic [31:0]  divWordOut;
  logic [3:0]   ticks;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  baseTickGen dut (
    .clk(clk), .rstN(rstN), .divWordIn(divWordIn), .divWordWe(divWordWe),
    .targetRates(targetRates), .calcStart(calcStart), .calcDone(calcDone),
    .divWordOut(divWordOut), .ticks(ticks)
  );

  always #4 clk = ~clk;

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expCode(longint unsigned t);
    longint unsigned q;
    if (t == 0) return 8'hFF;
    q = (2 * P + t - 1) / t;
    if (q <= 2) return 8'd0;
    if (q - 2 > 254) return 8'hFF;
    return 8'(q - 2);
  endfunction

  function automatic int searchLen(logic [31:0] w);
    int n = 0;
    for (int j = 0; j < 4; j++) n += (w[8*j +: 8] == 8'hFF) ? 255 : int'(w[8*j +: 8]) + 1;
    return n;
  endfunction

  task automatic writeWord(logic [31:0] w);
    @(negedge clk);
    divWordIn = w; divWordWe = 1'b1;
    @(negedge clk);
    divWordWe = 1'b0;
    check(divWordOut == w, "R6 word load", divWordOut, w);
  endtask

  // R2/R3/R4: count ticks and gaps of one channel over two divisor periods
  task automatic measure(int ch, logic [7:0] code);
    int den = int'(code) + 2;
    int cnt = 0, lastT = -1, minG = 1000, maxG = 0;
    for (int i = 1; i <= 2 * den; i++) begin
      @(negedge clk);
      if (ticks[ch]) begin
        cnt++;
        if (lastT >= 0) begin
          if (i - lastT < minG) minG = i - lastT;
          if (i - lastT > maxG) maxG = i - lastT;
        end
        lastT = i;
      end
    end
    check(cnt == 4, (code == 0) ? "R4 code0 tick count" : "R2 ticks per window", cnt, 4);
    check(minG == den / 2, "R3 min spacing", minG, den / 2);
    check(maxG == (den + 1) / 2, "R3 max spacing", maxG, (den + 1) / 2);
  endtask

  task automatic rateRound(logic [31:0] w);
    writeWord(w);
    repeat (300) @(negedge clk);
    for (int ch = 0; ch < 4; ch++) measure(ch, w[8*ch +: 8]);
  endtask

  task automatic runCalc(logic [127:0] tg, bit extraStart, bit holdWe, output int cnt);
    @(negedge clk);
    targetRates = tg;
    calcStart = 1'b1;
    if (holdWe) begin divWordIn = 32'hA5A5A5A5; divWordWe = 1'b1; end
    cnt = 0;
    do begin
      @(negedge clk);
      calcStart = 1'b0;
      cnt++;
      if (extraStart && cnt == 5) calcStart = 1'b1;
      if (holdWe && cnt == 20)
        check(divWordOut == 32'hA5A5A5A5, "R6 write during search", divWordOut, 32'hA5A5A5A5);
    end while (!calcDone && cnt < 3000);
    calcStart = 1'b0;
    divWordWe = 1'b0;
  endtask

  task automatic calcCase(logic [127:0] tg, bit extraStart, bit holdWe);
    logic [31:0] ew;
    int cnt;
    for (int j = 0; j < 4; j++) ew[8*j +: 8] = expCode(longint'(tg[32*j +: 32]));
    runCalc(tg, extraStart, holdWe, cnt);
    check(cnt == searchLen(ew) + 1, "R8 done timing", cnt, searchLen(ew) + 1);
    check(divWordOut == ew, holdWe ? "R9 commit beats write" : "R7 searched word",
          divWordOut, ew);
    @(negedge clk);
    check(!calcDone, "R8 done single cycle", calcDone, 0);
    check(divWordOut == ew, "R7 word kept", divWordOut, ew);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] defW;
    int gap;
    void'($urandom(32'd20210618));
    rstN = 1'b0; divWordIn = '0; divWordWe = 1'b0; calcStart = 1'b0;
    targetRates = {32'd40_000_000, 32'd10_000_000, 32'd4_000_000, 32'd1_000_000};
    repeat (4) @(negedge clk);
    defW = {expCode(40_000_000), expCode(10_000_000), expCode(4_000_000), expCode(1_000_000)};
    check(divWordOut == 32'h031230C6, "R1 reset word", divWordOut, 32'h031230C6);
    check(defW == 32'h031230C6, "R1 default codes", defW, 32'h031230C6);
    check(calcDone == 1'b0 && ticks == 4'b0, "R1 outputs idle", {calcDone, ticks}, 0);
    rstN = 1'b1;
    repeat (300) @(negedge clk);
    for (int ch = 0; ch < 4; ch++) measure(ch, defW[8*ch +: 8]);

    // directed extremes, then random words
    rateRound(32'h0001FEFF);
    for (int r = 0; r < 6; r++) rateRound($urandom());

    // R5: word changes right at a tick, in-flight interval keeps old divisor
    rateRound(32'h000000C6);
    do @(negedge clk); while (!ticks[0]);
    divWordIn = 32'h00000000; divWordWe = 1'b1;
    @(negedge clk);
    divWordWe = 1'b0;
    gap = 1;
    while (!ticks[0] && gap < 400) begin @(negedge clk); gap++; end
    check(gap == 100, "R5 old interval kept", gap, 100);
    @(negedge clk);
    check(ticks[0] == 1'b1, "R5 new code after tick", ticks[0], 1);

    // R6 hold with no write
    repeat (10) @(negedge clk);
    check(divWordOut == 32'h00000000, "R6 word held", divWordOut, 0);

    // calculator cases
    calcCase({32'd40_000_000, 32'd10_000_000, 32'd4_000_000, 32'd1_000_000}, 1'b0, 1'b0);
    calcCase({32'd0, 32'd781_249, 32'd781_250, 32'd300_000_000}, 1'b0, 1'b0);
    calcCase({32'd200_000_000, 32'd100_000, 32'd66_666_667, 32'd199_999_999}, 1'b0, 1'b0);
    for (int r = 0; r < 5; r++) begin
      logic [127:0] tg;
      for (int j = 0; j < 4; j++) tg[32*j +: 32] = 32'd400_000 + ($urandom() % 200_000_000);
      calcCase(tg, 1'b0, 1'b0);
    end
    // R9: write held high through search and commit edge
    calcCase({32'd40_000_000, 32'd10_000_000, 32'd4_000_000, 32'd1_000_000}, 1'b0, 1'b1);
    // R10: second start during search ignored
    calcCase({32'd40_000_000, 32'd10_000_000, 32'd4_000_000, 32'd1_000_000}, 1'b1, 1'b0);
    begin
      int extra = 0;
      for (int i = 0; i < 300; i++) begin
        @(negedge clk);
        if (calcDone) extra++;
      end
      check(extra == 0, "R10 no second done", extra, 0);
    end
    // rates after calculator commit
    for (int ch = 0; ch < 4; ch++) measure(ch, defW[8*ch +: 8]);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule